// File: doc/BRIEF.md
# Sampling Converter Start and Status Controller

This block is the digital control side of a sampling analog-to-digital converter. It decides when a conversion begins, keeps track of whether one is running, drives the track/hold control for the sampling stage, and produces the conversion status pin together with its output-enable. The analog conversion is replaced by a counter of fixed length, so the block behaves like the converter's sequencer in a system simulation or in a mixed-signal wrapper.

A mode pin picks one of two start rules. In the synchronous rule, a conversion starts when the start strobe falls while chip select is low. In the free-running rule, a falling start strobe is enough and chip select is ignored. The two rules also differ in how the status pin is driven. In the synchronous rule it is a three-state output, enabled by chip select and a status-enable input together. In the free-running rule it behaves as an open drain that only pulls low during a conversion, and an external pull-up supplies the high level.

The block also reports misuse. A strobe held low long enough to mean continuous conversion sets a warning. So do start strobes spaced closer than the minimum repeat interval, and requests that arrive while a conversion is still running. After reset, a power-up counter holds off every start until the internal logic is ready.

Top module: `adc_start_ctrl`

## Requirements
- R1: With `mode_sync`=1, a high-to-low transition of `start_n` sampled while `chip_sel_n`=0 starts a conversion, and `status` reads 0 from the next cycle. The same transition while `chip_sel_n`=1 starts nothing.
- R2: With `mode_sync`=0, a high-to-low transition of `start_n` starts a conversion whatever the level of `chip_sel_n`.
- R3: `status` is 1 while idle. It stays 0 for exactly CONV_CYCLES cycles after the start edge, then returns to 1. `conv_done` is high for exactly the one cycle in which `status` returns to 1.
- R4: `trk_hold` goes to 1 together with the start of a conversion. It returns to 0 after TRACK_CYCLES cycles, while the conversion is still running.
- R5: With `mode_sync`=1, `status_oe` is 1 exactly when `chip_sel_n`=0 and `stat_en_n`=0. It does not depend on whether a conversion is running.
- R6: With `mode_sync`=0, `status_oe` is 1 only while a conversion runs and `stat_en_n`=0. Whenever it is 1, `status` is 0.
- R7: Start requests are ignored until POR_CYCLES clock edges have passed since reset release.
- R8: A start request that arrives while a conversion runs does not restart or lengthen the conversion, and it sets the sticky `overrun` flag.
- R9: A start request fewer than MIN_GAP cycles after the previous accepted start raises `rate_warn` for one cycle. The request is still accepted if the converter is idle. The first start after reset is never flagged.
- R10: `cont_warn` is set, and stays set until reset, once the start condition has been held low for CONT_LIMIT consecutive cycles. The start condition is `start_n`=0 in free-running mode, and `start_n`=0 with `chip_sel_n`=0 in synchronous mode.
- R11: During and straight after reset, `status`=1, `trk_hold`=0, `conv_done`=0, and all warning flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sync | input | 1 | 1 selects the synchronous start rule, 0 the free-running rule |
| chip_sel_n | input | 1 | Active-low chip select |
| start_n | input | 1 | Active-low start strobe; its falling edge requests a conversion |
| stat_en_n | input | 1 | Active-low enable for the status pin |
| status | output | 1 | Conversion status level: 0 while converting, 1 when idle |
| status_oe | output | 1 | Output enable for the status pin |
| trk_hold | output | 1 | 1 puts the sampling stage in hold, 0 in track |
| conv_done | output | 1 | One-cycle pulse when a conversion ends |
| cont_warn | output | 1 | Sticky: continuous-conversion use detected |
| rate_warn | output | 1 | One-cycle pulse: start strobes closer than the minimum interval |
| overrun | output | 1 | Sticky: start request received while busy |

## Verification
The bench walks every combination of mode, chip select and status enable. If the synchronous gating were lost, a start with chip select high would pull `status` low. If the two status-enable rules were swapped, the free-running pin would drive while idle. Cycle-exact walks through a conversion catch an off-by-one in the conversion or hold length, and a done pulse that comes early or lasts too long. The bench also targets a strobe right after reset, a second strobe during a conversion, a strobe just inside the minimum repeat interval, and a strobe held low with chip select high in synchronous mode. A wrong design would start before it is ready, restart the counter, miss or over-report the rate warning, or take a deselected strobe as continuous use.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SYNC = 1'b1
    } start_mode_e;

endpackage

// File: rtl/adc_start_detect.sv
module adc_start_detect
    import adc_ctrl_pkg::*;
#(
    parameter int CONT_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sync,
    input  logic chip_sel_n,
    input  logic start_n,
    output logic req,
    output logic cont_warn
);
    localparam int LW = $clog2(CONT_LIMIT + 1);

    typedef struct packed {
        logic          strobe_prev;
        logic [LW-1:0] low_cnt;
        logic          cont;
    } det_t;

    det_t det_d, det_q;
    logic gated_ok;
    logic low_level;

    always_comb begin
        gated_ok  = (start_mode_e'(mode_sync) == MODE_FREE) || !chip_sel_n;
        low_level = !start_n && gated_ok;
        req       = det_q.strobe_prev && !start_n && gated_ok;

        det_d             = det_q;
        det_d.strobe_prev = start_n;
        if (low_level) begin
            if (det_q.low_cnt != LW'(CONT_LIMIT)) begin
                det_d.low_cnt = det_q.low_cnt + LW'(1);
            end
            if (det_q.low_cnt == LW'(CONT_LIMIT - 1)) begin
                det_d.cont = 1'b1;
            end
        end else begin
            det_d.low_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.strobe_prev <= 1'b1;
            det_q.low_cnt     <= '0;
            det_q.cont        <= 1'b0;
        end else begin
            det_q <= det_d;
        end
    end

    assign cont_warn = det_q.cont;

    AST_CONT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        det_q.cont |=> det_q.cont); // R10

    AST_CONT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q.cont) |-> $past(!start_n)); // R10

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int CONV_CYCLES  = 20,
    parameter int TRACK_CYCLES = 8,
    parameter int MIN_GAP      = 500,
    parameter int POR_CYCLES   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic trk_hold,
    output logic conv_done,
    output logic overrun,
    output logic rate_warn
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam int PW = $clog2(POR_CYCLES + 1);
    localparam int GW = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic [PW-1:0] por_cnt;
        logic          busy;
        logic [CW-1:0] cnt;
        logic          hold;
        logic          done;
        logic          ovr;
        logic [GW-1:0] gap;
        logic          rate;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ready;

    always_comb begin
        ready = (seq_q.por_cnt == PW'(POR_CYCLES));

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.rate = 1'b0;

        if (!ready) begin
            seq_d.por_cnt = seq_q.por_cnt + PW'(1);
        end
        if (seq_q.gap != GW'(MIN_GAP)) begin
            seq_d.gap = seq_q.gap + GW'(1);
        end

        if (seq_q.busy) begin
            if (seq_q.cnt == CW'(CONV_CYCLES - 1)) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.cnt  = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + CW'(1);
            end
            if (seq_q.hold && seq_q.cnt == CW'(TRACK_CYCLES - 1)) begin
                seq_d.hold = 1'b0;
            end
        end

        if (req && ready) begin
            if (seq_q.gap < GW'(MIN_GAP)) begin
                seq_d.rate = 1'b1;
            end
            if (seq_q.busy) begin
                seq_d.ovr = 1'b1;
            end else begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = '0;
                seq_d.hold = 1'b1;
                seq_d.gap  = GW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.por_cnt <= '0;
            seq_q.busy    <= 1'b0;
            seq_q.cnt     <= '0;
            seq_q.hold    <= 1'b0;
            seq_q.done    <= 1'b0;
            seq_q.ovr     <= 1'b0;
            seq_q.gap     <= GW'(MIN_GAP);
            seq_q.rate    <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = seq_q.busy;
    assign trk_hold  = seq_q.hold;
    assign conv_done = seq_q.done;
    assign overrun   = seq_q.ovr;
    assign rate_warn = seq_q.rate;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done); // R3

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (!seq_q.busy && $past(seq_q.busy))); // R3

    AST_HOLD_INSIDE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.hold |-> seq_q.busy); // R4

    AST_IDLE_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !seq_q.busy); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ovr |=> seq_q.ovr); // R8

endmodule

// File: rtl/adc_status_drive.sv
module adc_status_drive
    import adc_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sync,
    input  logic chip_sel_n,
    input  logic stat_en_n,
    input  logic busy,
    output logic status,
    output logic status_oe
);
    always_comb begin
        status = !busy;
        if (start_mode_e'(mode_sync) == MODE_SYNC) begin
            status_oe = !chip_sel_n && !stat_en_n;
        end else begin
            status_oe = busy && !stat_en_n;
        end
    end

    AST_FREE_PULLS_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && status_oe) |-> !status); // R6

endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
    parameter int CONV_CYCLES  = 20,
    parameter int TRACK_CYCLES = 8,
    parameter int MIN_GAP      = 500,
    parameter int POR_CYCLES   = 1000,
    parameter int CONT_LIMIT   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sync,
    input  logic chip_sel_n,
    input  logic start_n,
    input  logic stat_en_n,
    output logic status,
    output logic status_oe,
    output logic trk_hold,
    output logic conv_done,
    output logic cont_warn,
    output logic rate_warn,
    output logic overrun
);
    logic req;
    logic busy;

    adc_start_detect #(
        .CONT_LIMIT(CONT_LIMIT)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sync (mode_sync),
        .chip_sel_n(chip_sel_n),
        .start_n   (start_n),
        .req       (req),
        .cont_warn (cont_warn)
    );

    adc_conv_seq #(
        .CONV_CYCLES (CONV_CYCLES),
        .TRACK_CYCLES(TRACK_CYCLES),
        .MIN_GAP     (MIN_GAP),
        .POR_CYCLES  (POR_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .busy     (busy),
        .trk_hold (trk_hold),
        .conv_done(conv_done),
        .overrun  (overrun),
        .rate_warn(rate_warn)
    );

    adc_status_drive u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sync (mode_sync),
        .chip_sel_n(chip_sel_n),
        .stat_en_n (stat_en_n),
        .busy      (busy),
        .status    (status),
        .status_oe (status_oe)
    );

    AST_SYNC_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && chip_sel_n && !busy) |=> !busy); // R1

endmodule

// File: tb/tb_adc_start_ctrl.sv
module tb_adc_start_ctrl;
    localparam int CONV  = 10;
    localparam int TRACK = 4;
    localparam int GAP   = 40;
    localparam int POR   = 8;
    localparam int CONT  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sync = 1'b1;
    logic chip_sel_n = 1'b1;
    logic start_n = 1'b1;
    logic stat_en_n = 1'b1;
    logic status, status_oe, trk_hold, conv_done, cont_warn, rate_warn, overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_start_ctrl #(
        .CONV_CYCLES(CONV), .TRACK_CYCLES(TRACK), .MIN_GAP(GAP),
        .POR_CYCLES(POR), .CONT_LIMIT(CONT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .chip_sel_n(chip_sel_n),
        .start_n(start_n), .stat_en_n(stat_en_n), .status(status),
        .status_oe(status_oe), .trk_hold(trk_hold), .conv_done(conv_done),
        .cont_warn(cont_warn), .rate_warn(rate_warn), .overrun(overrun)
    );

    // {mode_sync, chip_sel_n, stat_en_n, expect_start, expect_oe_idle, expect_oe_busy}
    localparam logic [5:0] VEC [8] = '{
        6'b100_111, 6'b101_100, 6'b110_000, 6'b111_000,
        6'b000_101, 6'b010_101, 6'b011_100, 6'b001_100
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R11 reset state
        repeat (3) tick();
        chk("R11 status", status, 1);
        chk("R11 hold", trk_hold, 0);
        chk("R11 done", conv_done, 0);
        chk("R11 flags", {cont_warn, rate_warn, overrun}, 0);

        // R7 start right after reset is ignored
        mode_sync = 1'b0;
        rst_n = 1'b1;
        tick();
        start_n = 1'b0;
        tick();
        chk("R7 early start ignored", status, 1);
        start_n = 1'b1;
        repeat (POR + 4) tick();

        // stimulus table walk
        for (int i = 0; i < 8; i++) begin
            mode_sync  = VEC[i][5];
            chip_sel_n = VEC[i][4];
            stat_en_n  = VEC[i][3];
            start_n    = 1'b1;
            tick();
            #1;
            chk(mode_sync ? "R5 oe idle" : "R6 oe idle", status_oe, VEC[i][1]);
            start_n = 1'b0;
            tick();
            chk(mode_sync ? "R1 start" : "R2 start", status, !VEC[i][2]);
            chk("R9 no false rate flag", rate_warn, 0);
            #1;
            chk(mode_sync ? "R5 oe busy" : "R6 oe busy", status_oe, VEC[i][0]);
            start_n = 1'b1;
            repeat (GAP) tick();
        end

        // R3 / R4 cycle-exact walk
        mode_sync = 1'b0;
        stat_en_n = 1'b0;
        start_n = 1'b0;
        tick();
        chk("R3 status low at start", status, 0);
        chk("R4 hold at start", trk_hold, 1);
        start_n = 1'b1;
        for (int k = 1; k <= CONV + 1; k++) begin
            tick();
            chk("R3 status", status, (k >= CONV) ? 1 : 0);
            chk("R3 done", conv_done, (k == CONV) ? 1 : 0);
            chk("R4 hold", trk_hold, (k < TRACK) ? 1 : 0);
        end
        repeat (GAP) tick();

        // R8 overrun
        chk("R8 overrun clear", overrun, 0);
        start_n = 1'b0;
        tick();
        start_n = 1'b1;
        tick();
        start_n = 1'b0;
        tick();
        chk("R8 overrun set", overrun, 1);
        start_n = 1'b1;
        for (int k = 3; k <= CONV; k++) begin
            tick();
            if (k == CONV - 1) chk("R8 length kept (busy)", status, 0);
            if (k == CONV) chk("R8 length kept (end)", status, 1);
        end
        repeat (GAP) tick();

        // R9 rate warning
        start_n = 1'b0;
        tick();
        chk("R9 spaced start not flagged", rate_warn, 0);
        start_n = 1'b1;
        repeat (CONV + 2) tick();
        start_n = 1'b0;
        tick();
        chk("R9 close start flagged", rate_warn, 1);
        chk("R9 close start accepted", status, 0);
        start_n = 1'b1;
        tick();
        chk("R9 flag is a pulse", rate_warn, 0);
        repeat (GAP) tick();

        // R10 continuous detection
        mode_sync = 1'b1;
        chip_sel_n = 1'b1;
        start_n = 1'b0;
        repeat (CONT + 4) tick();
        chk("R10 deselected hold ignored", cont_warn, 0);
        start_n = 1'b1;
        tick();
        mode_sync = 1'b0;
        start_n = 1'b0;
        repeat (CONT - 1) tick();
        chk("R10 below limit", cont_warn, 0);
        tick();
        chk("R10 at limit", cont_warn, 1);
        start_n = 1'b1;
        tick();
        chk("R10 sticky", cont_warn, 1);

        finish_run();
    end
endmodule